// File: doc/BRIEF.md
# Four-Channel DMA Bus-Cycle Controller

The block moves bytes between memory and up to four peripherals without the CPU. A peripheral raises its request line; if that channel is enabled, the block asks the CPU for the bus with a hold request. Once hold acknowledge arrives, it picks the highest-priority pending channel and runs four-state bus cycles for it. Each cycle puts the low address byte on the address pins. It also puts the high address byte on the data bus and pulses a strobe, so that an external latch can hold the upper address. The block then drives the memory and I/O strobes that the channel's mode calls for.

Each channel keeps a 16-bit address, a 14-bit remaining-cycle count and a control word, all loaded through a simple write port. The bus stays held for back-to-back cycles while the granted request stays high. It is released when that request drops or when the channel's count runs out. The terminal-count output flags the final cycle, and the mark output flags every cycle whose count is a multiple of 128. Channel 2 can be set to reload itself from channel 3's registers at terminal count, which gives continuous buffering.

Top module: `dma4_ctrl`

## Requirements
- R1: Reset drives hrq_o, aen_o, adstb_o, data_oe_o, dack_o, all four bus strobes, tc_o and mark_o low, and clears every channel enable. A request on any line after reset then raises no hold request.
- R2: A request on an enabled channel raises hrq_o on the next clock edge. No bus cycle starts (aen_o stays low) until hlda_i has been sampled high.
- R3: Priority is fixed, with channel 0 highest. It is re-evaluated only between cycles, and at most one dack_o bit is high at a time.
- R4: In state S1, adstb_o pulses for exactly one clock. During that clock addr_o carries address bits 7:0, data_o carries bits 15:8 and data_oe_o is high.
- R5: aen_o is high in S1 through S4. The granted channel's dack_o bit is high in S2 through S4, and no strobe is active outside S2–S3.
- R6: In read mode (control bits 2:1 = 2), memr_o is high in S2 and S3, and iow_o is high in S3 only.
- R7: In write mode (control bits 2:1 = 1), ior_o is high in S2 and S3, and memw_o is high in S3 only.
- R8: In verify mode (control bits 2:1 = 0), cycles and acknowledges run as usual, but no memory or I/O strobe is asserted.
- R9: The address increments by one per cycle, with carry into the high byte. Cycles run back to back while the granted request is high at S4. If the request is low at S4, the bus is released, the enable is kept, and the next block continues at the following address.
- R10: The count register holds the number of cycles minus one. tc_o is high in S2–S4 of the cycle in which the count is 0. After that cycle hrq_o falls and the channel's enable clears.
- R11: mark_o is high in S2–S4 of every cycle whose count has bits 6:0 equal to 0.
- R12: A request on a channel whose enable (control bit 0) is clear is ignored, and hrq_o stays low.
- R13: With autoload (control bit 3) set on channel 2, terminal count on channel 2 reloads its address and count from channel 3 and keeps channel 2 enabled.
- R14: Register write: wr_fld_i 0 loads the address, 1 loads count bits 13:0, and 2 loads the control word of channel wr_ch_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_ch_i | input | 2 | Channel selected for the write |
| wr_fld_i | input | 2 | Field selected: 0 address, 1 count, 2 control |
| wr_data_i | input | 16 | Write data |
| drq_i | input | 4 | Per-channel transfer request |
| dack_o | output | 4 | Per-channel acknowledge |
| hrq_o | output | 1 | Hold request to the CPU |
| hlda_i | input | 1 | Hold acknowledge from the CPU |
| aen_o | output | 1 | Address enable, high during a bus cycle |
| adstb_o | output | 1 | Strobe for latching the high address byte |
| addr_o | output | 8 | Address bits 7:0 |
| data_o | output | 8 | Address bits 15:8 during S1 |
| data_oe_o | output | 1 | data_o drive enable |
| memr_o | output | 1 | Memory read strobe |
| memw_o | output | 1 | Memory write strobe |
| ior_o | output | 1 | I/O read strobe |
| iow_o | output | 1 | I/O write strobe |
| tc_o | output | 1 | Final cycle of the channel's count |
| mark_o | output | 1 | Cycle count is a multiple of 128 |

## Verification
A request presented before a clock edge shows up on hrq_o right after that edge. S1 comes one edge after hlda_i is sampled high, and S2, S3 and S4 each follow one edge apart. The next S1 or the release of hrq_o comes one edge after S4. The bench drives inputs two time units after each rising edge and checks outputs at that same point, once per state. For variable hold latency it waits for the adstb_o pulse, then checks every state of the cycle in turn against the address, count and mode it tracks itself.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ, ST_S1, ST_S2, ST_S3, ST_S4
  } dma_st_e;

  localparam logic [1:0] MD_VERIFY = 2'd0;
  localparam logic [1:0] MD_WRITE  = 2'd1;
  localparam logic [1:0] MD_READ   = 2'd2;

  localparam logic [1:0] FLD_ADDR = 2'd0;
  localparam logic [1:0] FLD_CNT  = 2'd1;
  localparam logic [1:0] FLD_CTRL = 2'd2;
endpackage

// File: rtl/dma4_prio.sv
module dma4_prio #(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic [NCH-1:0] req_i,
  output logic [IW-1:0]  idx_o,
  output logic           any_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/dma4_chan.sv
module dma4_chan
  import dma4_pkg::*;
#(
  parameter int AW     = 16,
  parameter int CW     = 14,
  parameter bit RELOAD = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_sel_i,
  input  logic [1:0]    wr_fld_i,
  input  logic [AW-1:0] wr_data_i,
  input  logic          step_i,
  input  logic [AW-1:0] ld_addr_i,
  input  logic [CW-1:0] ld_cnt_i,
  output logic [AW-1:0] addr_o,
  output logic [CW-1:0] cnt_o,
  output logic          en_o,
  output logic [1:0]    mode_o
);
  logic auto_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      cnt_o  <= '0;
      en_o   <= 1'b0;
      mode_o <= MD_VERIFY;
      auto_q <= 1'b0;
    end else if (wr_sel_i) begin
      case (wr_fld_i)
        FLD_ADDR: addr_o <= wr_data_i;
        FLD_CNT:  cnt_o  <= wr_data_i[CW-1:0];
        FLD_CTRL: begin
          en_o   <= wr_data_i[0];
          mode_o <= wr_data_i[2:1];
          auto_q <= wr_data_i[3];
        end
        default: ;
      endcase
    end else if (step_i) begin
      if (cnt_o == '0) begin
        if (RELOAD && auto_q) begin
          addr_o <= ld_addr_i;
          cnt_o  <= ld_cnt_i;
        end else begin
          addr_o <= addr_o + 1'b1;
          en_o   <= 1'b0;
        end
      end else begin
        addr_o <= addr_o + 1'b1;
        cnt_o  <= cnt_o - 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma4_seq.sv
module dma4_seq
  import dma4_pkg::*;
#(
  parameter int NCH = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] req_i,
  input  logic [NCH-1:0] drq_i,
  input  logic           hlda_i,
  input  logic [IW-1:0]  win_i,
  input  logic           last_i,
  output dma_st_e        st_o,
  output logic [IW-1:0]  gnt_o
);
  dma_st_e       st_d;
  logic [IW-1:0] gnt_d;
  logic          keep;

  assign keep = hlda_i && drq_i[gnt_o] && !last_i && (|req_i);

  always_comb begin
    st_d  = st_o;
    gnt_d = gnt_o;
    unique case (st_o)
      ST_IDLE: if (|req_i) st_d = ST_REQ;
      ST_REQ: begin
        if (!(|req_i)) st_d = ST_IDLE;
        else if (hlda_i) begin
          st_d  = ST_S1;
          gnt_d = win_i;
        end
      end
      ST_S1: st_d = ST_S2;
      ST_S2: st_d = ST_S3;
      ST_S3: st_d = ST_S4;
      ST_S4: begin
        if (keep) begin
          st_d  = ST_S1;
          gnt_d = win_i; // re-arbitrate between cycles
        end else st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_o  <= ST_IDLE;
      gnt_o <= '0;
    end else begin
      st_o  <= st_d;
      gnt_o <= gnt_d;
    end
  end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
  import dma4_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int AW       = 16,
  parameter int CW       = 14,
  parameter int MARK_W   = 7,
  parameter int AUTO_DST = 2,
  parameter int AUTO_SRC = 3,
  localparam int IW = $clog2(NCH),
  localparam int BW = AW / 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [IW-1:0]  wr_ch_i,
  input  logic [1:0]     wr_fld_i,
  input  logic [AW-1:0]  wr_data_i,
  input  logic [NCH-1:0] drq_i,
  output logic [NCH-1:0] dack_o,
  output logic           hrq_o,
  input  logic           hlda_i,
  output logic           aen_o,
  output logic           adstb_o,
  output logic [BW-1:0]  addr_o,
  output logic [BW-1:0]  data_o,
  output logic           data_oe_o,
  output logic           memr_o,
  output logic           memw_o,
  output logic           ior_o,
  output logic           iow_o,
  output logic           tc_o,
  output logic           mark_o
);
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic [NCH-1:0][CW-1:0] ch_cnt;
  logic [NCH-1:0][1:0]    ch_mode;
  logic [NCH-1:0]         ch_en;
  logic [NCH-1:0]         req;
  logic [IW-1:0]          win, gnt;
  logic                   any;
  dma_st_e                st;

  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cur_cnt;
  logic [1:0]    cur_mode;
  logic          in_cyc, ack_ph, rd_ph, wr_ph, last;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma4_chan #(
      .AW(AW), .CW(CW), .RELOAD(i == AUTO_DST)
    ) u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_sel_i  (wr_en_i && (wr_ch_i == IW'(i))),
      .wr_fld_i  (wr_fld_i),
      .wr_data_i (wr_data_i),
      .step_i    ((st == ST_S4) && (gnt == IW'(i))),
      .ld_addr_i (ch_addr[AUTO_SRC]),
      .ld_cnt_i  (ch_cnt[AUTO_SRC]),
      .addr_o    (ch_addr[i]),
      .cnt_o     (ch_cnt[i]),
      .en_o      (ch_en[i]),
      .mode_o    (ch_mode[i])
    );
  end

  assign req = drq_i & ch_en;

  dma4_prio #(.NCH(NCH)) u_prio (
    .req_i (req),
    .idx_o (win),
    .any_o (any)
  );

  assign cur_addr = ch_addr[gnt];
  assign cur_cnt  = ch_cnt[gnt];
  assign cur_mode = ch_mode[gnt];
  assign last     = (cur_cnt == '0);

  dma4_seq #(.NCH(NCH)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req),
    .drq_i  (drq_i),
    .hlda_i (hlda_i),
    .win_i  (win),
    .last_i (last),
    .st_o   (st),
    .gnt_o  (gnt)
  );

  assign in_cyc = (st == ST_S1) || ack_ph;
  assign ack_ph = (st == ST_S2) || (st == ST_S3) || (st == ST_S4);
  assign rd_ph  = (st == ST_S2) || (st == ST_S3);
  assign wr_ph  = (st == ST_S3);

  assign hrq_o     = (st != ST_IDLE);
  assign aen_o     = in_cyc;
  assign adstb_o   = (st == ST_S1);
  assign data_oe_o = (st == ST_S1);
  assign data_o    = (st == ST_S1) ? cur_addr[AW-1:BW] : '0;
  assign addr_o    = in_cyc ? cur_addr[BW-1:0] : '0;
  assign dack_o    = ack_ph ? (NCH'(1) << gnt) : '0;

  assign memr_o = rd_ph && (cur_mode == MD_READ);
  assign iow_o  = wr_ph && (cur_mode == MD_READ);
  assign ior_o  = rd_ph && (cur_mode == MD_WRITE);
  assign memw_o = wr_ph && (cur_mode == MD_WRITE);

  assign tc_o   = ack_ph && last;
  assign mark_o = ack_ph && (cur_cnt[MARK_W-1:0] == '0);

  logic unused_any;
  assign unused_any = any;
endmodule

// File: rtl/dma4_ctrl_chk.sv
module dma4_ctrl_chk #(
  parameter int NCH = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           hlda_i,
  input logic           hrq_o,
  input logic           aen_o,
  input logic           adstb_o,
  input logic [NCH-1:0] dack_o,
  input logic           memr_o,
  input logic           memw_o,
  input logic           ior_o,
  input logic           iow_o,
  input logic           tc_o
);
  logic any_stb;
  assign any_stb = memr_o || memw_o || ior_o || iow_o;

  AST_ONE_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(dack_o)); // R3
  AST_AEN_AFTER_HLDA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aen_o) |-> $past(hlda_i)); // R2
  AST_AEN_UNDER_HRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_o |-> hrq_o); // R2
  AST_ADSTB_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adstb_o |=> !adstb_o); // R4
  AST_STB_NEEDS_DACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_stb |-> (aen_o && (dack_o != '0))); // R5
  AST_IOW_AFTER_MEMR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(iow_o) |-> memr_o); // R6
  AST_MEMW_AFTER_IOR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(memw_o) |-> ior_o); // R7
  AST_TC_IN_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tc_o |-> (dack_o != '0)); // R10
endmodule

bind dma4_ctrl dma4_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .hlda_i  (hlda_i),
  .hrq_o   (hrq_o),
  .aen_o   (aen_o),
  .adstb_o (adstb_o),
  .dack_o  (dack_o),
  .memr_o  (memr_o),
  .memw_o  (memw_o),
  .ior_o   (ior_o),
  .iow_o   (iow_o),
  .tc_o    (tc_o)
);

// File: tb/dma4_ctrl_test.sv
module dma4_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_ch = '0;
  logic [1:0]  wr_fld = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  drq = '0;
  logic [3:0]  dack;
  logic        hrq, hlda, aen, adstb, data_oe, memr, memw, ior, iow, tc, mark;
  logic [7:0]  addr, data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  // CPU model: grants hold one clock after the request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) hlda <= 1'b0;
    else        hlda <= hrq;
  end

  dma4_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_ch_i(wr_ch),
    .wr_fld_i(wr_fld), .wr_data_i(wr_data), .drq_i(drq), .dack_o(dack),
    .hrq_o(hrq), .hlda_i(hlda), .aen_o(aen), .adstb_o(adstb),
    .addr_o(addr), .data_o(data), .data_oe_o(data_oe), .memr_o(memr),
    .memw_o(memw), .ior_o(ior), .iow_o(iow), .tc_o(tc), .mark_o(mark)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] ch, input logic [1:0] fld, input logic [15:0] d);
    wr_en = 1'b1; wr_ch = ch; wr_fld = fld; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic prog(input logic [1:0] ch, input logic [15:0] a, input logic [13:0] c,
                      input logic [3:0] ctrl);
    wr(ch, 2'd0, a);   // R14
    wr(ch, 2'd1, {2'b00, c});
    wr(ch, 2'd2, {12'h000, ctrl});
  endtask

  task automatic wait_s1();
    for (int i = 0; i < 40; i++) begin
      if (adstb) return;
      step();
    end
    chk("R2 wait for cycle start", 32'(adstb), 32'd1);
  endtask

  // observe one bus cycle starting at S1; ends at S4
  task automatic do_cycle(input int ch, input logic [15:0] a, input int md,
                          input bit etc, input bit emark, input bit drop);
    string mt;
    mt = (md == 2) ? "R6" : (md == 1) ? "R7" : "R8";
    chk("R4 adstb S1", 32'(adstb), 32'd1);
    chk("R4 addr lo", 32'(addr), 32'(a[7:0]));
    chk("R4 addr hi", 32'(data), 32'(a[15:8]));
    chk("R4 data_oe", 32'(data_oe), 32'd1);
    chk("R5 aen S1", 32'(aen), 32'd1);
    chk("R5 no dack S1", 32'(dack), 32'd0);
    step();
    chk("R4 adstb S2", 32'(adstb), 32'd0);
    chk("R3 dack S2", 32'(dack), 32'(4'b1 << ch));
    chk({mt, " S2 strobes"}, 32'({memr, ior, memw, iow}),
        32'({md == 2, md == 1, 1'b0, 1'b0}));
    chk("R10 tc", 32'(tc), 32'(etc));
    chk("R11 mark", 32'(mark), 32'(emark));
    if (drop) drq[ch] = 1'b0;
    step();
    chk({mt, " S3 strobes"}, 32'({memr, ior, memw, iow}),
        32'({md == 2, md == 1, md == 1, md == 2}));
    step();
    chk("R5 S4 strobes off", 32'({memr, ior, memw, iow}), 32'd0);
    chk("R5 dack S4", 32'(dack), 32'(4'b1 << ch));
    chk("R5 aen S4", 32'(aen), 32'd1);
    chk("R10 tc S4", 32'(tc), 32'(etc));
  endtask

  task automatic t_reset();
    chk("R1 hrq", 32'(hrq), 32'd0);
    chk("R1 outputs", 32'({aen, adstb, data_oe, dack, memr, memw, ior, iow, tc, mark}), 32'd0);
    drq = 4'hf;
    for (int i = 0; i < 4; i++) begin
      step();
      chk("R1 enables clear", 32'(hrq), 32'd0);
    end
    drq = '0;
  endtask

  task automatic t_read_block();
    prog(2'd0, 16'h12FE, 14'd2, 4'b0101);
    drq[0] = 1'b1;
    step();
    chk("R2 hrq next edge", 32'(hrq), 32'd1);
    chk("R2 no cycle before hlda", 32'(aen), 32'd0);
    wait_s1();
    do_cycle(0, 16'h12FE, 2, 1'b0, 1'b0, 1'b0); step();
    do_cycle(0, 16'h12FF, 2, 1'b0, 1'b0, 1'b0); step();
    do_cycle(0, 16'h1300, 2, 1'b1, 1'b1, 1'b0); step();
    chk("R10 hold released", 32'(hrq), 32'd0);
    for (int i = 0; i < 3; i++) step();
    chk("R10 enable cleared", 32'(hrq), 32'd0);
    drq[0] = 1'b0;
  endtask

  task automatic t_write_drop();
    prog(2'd1, 16'h4000, 14'd10, 4'b0011);
    drq[1] = 1'b1;
    wait_s1();
    do_cycle(1, 16'h4000, 1, 1'b0, 1'b0, 1'b0); step();
    do_cycle(1, 16'h4001, 1, 1'b0, 1'b0, 1'b1); step();
    chk("R9 release on drop", 32'(hrq), 32'd0);
    chk("R9 no further cycle", 32'(adstb), 32'd0);
    step();
    drq[1] = 1'b1;
    wait_s1();
    do_cycle(1, 16'h4002, 1, 1'b0, 1'b0, 1'b1); step();
    chk("R9 release again", 32'(hrq), 32'd0);
    step();
  endtask

  task automatic t_verify_mark();
    prog(2'd1, 16'h0100, 14'd129, 4'b0001);
    drq[1] = 1'b1;
    wait_s1();
    for (int k = 0; k < 130; k++) begin
      do_cycle(1, 16'h0100 + 16'(k), 0, k == 129, ((129 - k) % 128) == 0, 1'b0);
      step();
    end
    chk("R10 verify block end", 32'(hrq), 32'd0);
    drq[1] = 1'b0;
    step();
  endtask

  task automatic t_priority();
    prog(2'd0, 16'h2000, 14'd1, 4'b0101);
    prog(2'd1, 16'h3000, 14'd0, 4'b0011);
    drq[0] = 1'b1; drq[1] = 1'b1;
    wait_s1();
    do_cycle(0, 16'h2000, 2, 1'b0, 1'b0, 1'b0); step();
    do_cycle(0, 16'h2001, 2, 1'b1, 1'b1, 1'b0); step();
    chk("R3 release after ch0 tc", 32'(hrq), 32'd0);
    wait_s1();
    do_cycle(1, 16'h3000, 1, 1'b1, 1'b1, 1'b0); step();
    drq = '0;
    step();
    // higher priority joins between cycles
    prog(2'd1, 16'h5000, 14'd5, 4'b0101);
    prog(2'd0, 16'h6000, 14'd0, 4'b0101);
    drq[1] = 1'b1;
    wait_s1();
    do_cycle(1, 16'h5000, 2, 1'b0, 1'b0, 1'b0);
    drq[0] = 1'b1;
    step();
    chk("R3 preempt at boundary", 32'(adstb), 32'd1);
    do_cycle(0, 16'h6000, 2, 1'b1, 1'b1, 1'b0); step();
    drq[0] = 1'b0;
    wait_s1();
    do_cycle(1, 16'h5001, 2, 1'b0, 1'b0, 1'b1); step();
    chk("R3 done", 32'(hrq), 32'd0);
    step();
  endtask

  task automatic t_autoload();
    prog(2'd3, 16'h7000, 14'd1, 4'b0000);
    prog(2'd2, 16'h8000, 14'd0, 4'b1101);
    drq[2] = 1'b1;
    wait_s1();
    do_cycle(2, 16'h8000, 2, 1'b1, 1'b1, 1'b0); step();
    chk("R13 release at tc", 32'(hrq), 32'd0);
    wait_s1();
    do_cycle(2, 16'h7000, 2, 1'b0, 1'b0, 1'b0); step();
    do_cycle(2, 16'h7001, 2, 1'b1, 1'b1, 1'b0); step();
    wait_s1();
    do_cycle(2, 16'h7000, 2, 1'b0, 1'b0, 1'b1); step();
    chk("R13 done", 32'(hrq), 32'd0);
    step();
  endtask

  task automatic t_disabled();
    drq[3] = 1'b1;
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R12 disabled ignored", 32'({hrq, aen, dack}), 32'd0);
    end
    drq[3] = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_read_block();
    t_write_drop();
    t_verify_mark();
    t_priority();
    t_autoload();
    t_disabled();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule